// File: doc/BRIEF.md
# Serial Zero-Run Counter

This block judges an 8-bit word that arrives one bit per clock on a serial input. A start input marks the first bit of each word. The next bits follow on consecutive clocks with no gaps. While the word streams in, the block counts its zero bits. It also watches whether those zeros stay together in one unbroken run. A word is legal when its zeros form one contiguous run or when it has no zeros at all.

When the last bit has been taken, the block publishes two results: the zero count and a legality error flag. In the same step it raises a one-cycle completion strobe. An illegal word always reports a count of zero. The published results stay unchanged until the next word completes. A new word may start in the very cycle the strobe is high, so words can run back to back without idle cycles. Asserting start part-way through a word abandons that word and begins a new one.

The order in which bits are sent does not change the result. The bench sends the most significant bit first.

Top module: `zero_run_serial`

## Requirements
- R1: A synchronous active-high reset drives count_o to 0, error_o low and done_o low, abandons any word in progress, and the block then stays idle until start_i.
- R2: A word begins on the clock where start_i is high, which takes its first bit. Exactly FRAME_W bits are taken, one per clock. done_o is high for exactly one cycle, in the cycle right after the clock that took the last bit.
- R3: For a legal word, count_o shows the number of zero bits. A word of all ones gives count 0 with error_o low, and 11000111 gives count 3 with error_o low.
- R4: A word of all zeros is legal and gives count FRAME_W (8) with error_o low.
- R5: A word whose zeros form two or more separate runs gives error_o high and count_o 0 (for example 00111100). Bits after the second run begins cannot clear the error or raise the count.
- R6: count_o and error_o change only in the cycle where done_o is high or on reset. Bits presented while no word is active are ignored: done_o stays low and the outputs hold.
- R7: start_i asserted in the middle of a word discards that word without any done_o pulse. The new word is judged on its own bits only.
- R8: start_i may be asserted in the cycle where done_o is high. The next word is then taken with no idle cycle, and both words report correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | High with the first bit of a word |
| bit_i | input | 1 | Serial data bit |
| count_o | output | $clog2(FRAME_W+1) | Published zero count of the last completed word |
| error_o | output | 1 | Published legality error of the last completed word |
| done_o | output | 1 | One-cycle strobe: a new result has been published |

## Verification
Two events can fall in the same cycle. The first is the completion strobe of one word. The second is the start, and first bit, of the next word. The bench provokes this overlap by sending all 256 possible words back to back, so that every word's start is driven in the cycle its predecessor's strobe is high. Each result is judged against a zero count and a run count computed arithmetically from the word value. The bench also checks that outputs stay steady during the following word's bits. A second overlap is a restart during a word's run. It is provoked by truncating a word after four bits, and it is judged by the absence of any strobe for the abandoned word and a clean result for the new one.

// File: rtl/zrs_pkg.sv
package zrs_pkg;

    // Run-tracking flags carried from bit to bit within one word
    typedef struct packed {
        logic seen;    // at least one zero taken
        logic ended;   // a one has followed the first zero run
        logic err;     // a second zero run has started
    } zrs_flags_t;

endpackage

// File: rtl/zrs_judge.sv
module zrs_judge
    import zrs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  zrs_flags_t       flags_cur,
    input  logic [CNT_W-1:0] cnt_cur,
    input  logic             bit_i,
    output zrs_flags_t       flags_nxt,
    output logic [CNT_W-1:0] cnt_nxt
);

    always_comb begin
        flags_nxt = flags_cur;
        cnt_nxt   = cnt_cur;
        if (!flags_cur.err) begin
            if (!bit_i && flags_cur.ended) begin
                // second zero run: illegal, count forced to zero
                flags_nxt.err = 1'b1;
                cnt_nxt       = '0;
            end else if (bit_i && flags_cur.seen) begin
                flags_nxt.ended = 1'b1;
            end else if (!bit_i) begin
                flags_nxt.seen = 1'b1;
                cnt_nxt        = cnt_cur + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/zrs_position.sv
module zrs_position #(
    parameter int FRAME_W = 8,
    parameter int POS_W   = 3
) (
    input  logic [POS_W-1:0] pos_cur,
    output logic [POS_W-1:0] pos_nxt,
    output logic             is_last
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);

    always_comb begin
        is_last = (pos_cur == LAST_POS);
        pos_nxt = is_last ? '0 : pos_cur + POS_W'(1);
    end

endmodule

// File: rtl/zero_run_serial.sv
module zero_run_serial
    import zrs_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(FRAME_W + 1),
    localparam int POS_W  = (FRAME_W > 2) ? $clog2(FRAME_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             bit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             error_o,
    output logic             done_o
);

    typedef struct packed {
        logic             busy;
        logic [POS_W-1:0] pos;
        zrs_flags_t       fl;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] ocnt;
        logic             oerr;
        logic             done;
    } zrs_state_t;

    zrs_state_t st_d, st_q;

    // Word context seen by the current bit: fresh on start, carried otherwise
    zrs_flags_t       base_fl;
    logic [CNT_W-1:0] base_cnt;
    logic [POS_W-1:0] base_pos;
    logic             take;

    assign take     = start_i | st_q.busy;
    assign base_fl  = start_i ? '0 : st_q.fl;
    assign base_cnt = start_i ? '0 : st_q.wcnt;
    assign base_pos = start_i ? '0 : st_q.pos;

    zrs_flags_t       j_fl;
    logic [CNT_W-1:0] j_cnt;
    logic [POS_W-1:0] p_nxt;
    logic             p_last;

    zrs_judge #(.CNT_W(CNT_W)) u_judge (
        .flags_cur (base_fl),
        .cnt_cur   (base_cnt),
        .bit_i     (bit_i),
        .flags_nxt (j_fl),
        .cnt_nxt   (j_cnt)
    );

    zrs_position #(.FRAME_W(FRAME_W), .POS_W(POS_W)) u_pos (
        .pos_cur (base_pos),
        .pos_nxt (p_nxt),
        .is_last (p_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (take) begin
            st_d.fl   = j_fl;
            st_d.wcnt = j_cnt;
            st_d.pos  = p_nxt;
            if (p_last) begin
                st_d.busy = 1'b0;
                st_d.ocnt = j_cnt;
                st_d.oerr = j_fl.err;
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.ocnt;
    assign error_o = st_q.oerr;
    assign done_o  = st_q.done;

endmodule

// File: rtl/zero_run_serial_props.sv
module zero_run_serial_props #(
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             bit_i,
    input logic [CNT_W-1:0] count_o,
    input logic             error_o,
    input logic             done_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (count_o == '0) && !error_o && !done_o); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        count_o <= CNT_W'(FRAME_W)); // R3

    AST_ERR_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        error_o |-> (count_o == '0)); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !$past(rst)) |-> ($stable(count_o) && $stable(error_o))); // R6

endmodule

bind zero_run_serial zero_run_serial_props #(.FRAME_W(FRAME_W)) u_props (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .bit_i   (bit_i),
    .count_o (count_o),
    .error_o (error_o),
    .done_o  (done_o)
);

// File: tb/zero_run_serial_bench.sv
module zero_run_serial_bench;

    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       bit_i = 1'b0;
    logic [3:0] count_o;
    logic       error_o;
    logic       done_o;

    int total = 0;
    int bad = 0;

    int    pub_cnt = 0;
    int    pub_err = 0;
    int    exp_cnt = 0;
    int    exp_err = 0;
    bit    pend = 1'b0;
    string pend_tag = "";

    always #2 clk = ~clk;

    zero_run_serial u_zero_run_serial (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .bit_i   (bit_i),
        .count_o (count_o),
        .error_o (error_o),
        .done_o  (done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Arithmetic model: zero count and number of separate zero runs
    task automatic model(input logic [7:0] v, output int c, output int e);
        int zeros = 0;
        int runs = 0;
        for (int i = 0; i < W; i++) begin
            if (!v[i]) begin
                zeros++;
                if (i == 0 || v[i-1]) runs++;
            end
        end
        e = (runs > 1) ? 1 : 0;
        c = e ? 0 : zeros;
    endtask

    task automatic check_pending();
        chk({"R2/R8 done strobe ", pend_tag}, done_o, 1);
        chk({"count ", pend_tag}, count_o, exp_cnt);
        chk({"R5 error ", pend_tag}, error_o, exp_err);
        pub_cnt = exp_cnt;
        pub_err = exp_err;
        pend = 1'b0;
    endtask

    // Send the first nbits of v, MSB first; a full word leaves its result pending
    task automatic send(input logic [7:0] v, input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i == 0 && pend) begin
                check_pending();
            end else if (i > 0) begin
                chk("R2 no strobe mid-word", done_o, 0);
                chk("R6 count held mid-word", count_o, pub_cnt);
                chk("R6 error held mid-word", error_o, pub_err);
            end
            start_i = (i == 0);
            bit_i   = v[W-1-i];
        end
        if (nbits == W) begin
            model(v, exp_cnt, exp_err);
            pend_tag = tag;
            pend = 1'b1;
        end
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) check_pending();
        start_i = 1'b0;
        bit_i   = 1'b0;
    endtask

    task automatic idle_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({tag, " no strobe while idle"}, done_o, 0);
            chk({tag, " count held while idle"}, count_o, pub_cnt);
            chk({tag, " error held while idle"}, error_o, pub_err);
            start_i = 1'b0;
            bit_i   = i[0];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", count_o, 0);
        chk("R1 reset error", error_o, 0);
        chk("R1 reset done", done_o, 0);
        rst = 1'b0;

        // R6: bits without start are ignored
        idle_check(6, "R6");

        // Exhaustive back-to-back sweep: R3, R4, R5, R8
        for (int v = 0; v < 256; v++) begin
            send(v[7:0], W, (v == 0) ? "R4 all zeros" : "R3 sweep");
        end
        flush();

        send(8'hFF, W, "R3 all ones");
        flush();
        send(8'hC7, W, "R3 one run of three");
        flush();
        send(8'h3C, W, "R5 two runs");
        flush();
        send(8'h55, W, "R5 error sticky");
        flush();

        idle_check(10, "R6");

        // R7: restart after four bits of an all-zero word
        send(8'h00, 4, "R7 abandoned");
        send(8'hC7, W, "R7 restarted word");
        flush();
        idle_check(6, "R7");

        // R1: reset in the middle of a word, with a nonzero published count
        send(8'h0F, 3, "R1 cut");
        @(negedge clk);
        rst     = 1'b1;
        start_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid-word reset count", count_o, 0);
        chk("R1 mid-word reset error", error_o, 0);
        chk("R1 mid-word reset done", done_o, 0);
        pub_cnt = 0;
        pub_err = 0;
        idle_check(10, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule